// File: doc/BRIEF.md
# MMC Card Identification Controller

This block is the card-side sequencer for the identification phase of an MMC card. A command decoder in front of it passes each host command as an index, a 32-bit argument and a one-cycle strobe. The controller answers the operating-condition command with an OCR word and checks the host's voltage window against the card's supply range. It then joins the broadcast CID round: it shifts its CID onto a wired-AND open-drain line one bit per clock and watches the line to find out whether another card won the round. Finally, it takes its relative address and leaves identification for good.

The states are Idle (0), Ready (1), Identification (2), Standby (3), Inactive (4) and CID-transmit (5).
- After reset the card sits in Idle.
- Idle goes to Ready on a compatible CMD1 once the power-up busy period has ended.
- Ready goes to CID-transmit on CMD2.
- CID-transmit goes to Identification after a clean transmission, or back to Ready on a lost bit.
- Identification goes to Standby on CMD3.
- Idle goes to Inactive on a CMD1 with an incompatible window.
- Any state other than CID-transmit goes to Inactive on CMD15.
- Inactive is left only through reset.

Command indices are 1 (operating condition), 2 (broadcast CID), 3 (set relative address) and 15 (go inactive).

Top module: `mmc_ident_ctrl`

## Requirements
- R1: After reset, card_state is 0 (Idle), od_drive_low, push_pull and ocr_valid are 0, and rca is 0.
- R2: For BUSY_CLKS clocks after reset the card is busy. A compatible CMD1 in Idle during that period yields ocr_value 0x00FF8000 and the card stays in Idle.
- R3: A compatible CMD1 in Idle after the busy period yields ocr_valid for exactly one cycle, in the cycle after the strobe, with ocr_value 0x80FF8000, and the card moves to Ready (1).
- R4: A CMD1 whose argument bits 23..0 are all zero is a query: the card answers with the OCR and stays in Idle.
- R5: A CMD1 in Idle whose argument bits 23..0 are non-zero but share no bit with 0x00FF8000 moves the card to Inactive (4) with no response. In Inactive every command is ignored, and only reset returns the card to Idle.
- R6: CMD15 moves the card to Inactive from Idle, Ready, Identification or Standby.
- R7: CMD2 in Ready enters CID-transmit (5). In the k-th cycle after the strobe (k from 0), od_drive_low equals the inverse of CID bit CID_W-1-k, so the CID is sent MSB first.
- R8: If the sampled line differs from the bit the card sent, the card stops driving in the next cycle and returns to Ready. A low line while the card also sends 0 is not a mismatch.
- R9: After all CID_W bits are sent without a mismatch, the card is in Identification (2).
- R10: CMD3 in Identification stores argument bits 31..16 in rca, moves the card to Standby (3) and sets push_pull.
- R11: In Standby, commands 1, 2 and 3 are ignored: the state, rca and push_pull do not change, no OCR is sent and the line is not driven.
- R12: Commands not valid in the current state are ignored, including CMD2 in Idle, CMD3 in Ready and any command during CID-transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, stands for a power cycle |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| line_in | input | 1 | Sampled value of the wired open-drain command line |
| od_drive_low | output | 1 | Pull the open-drain line low |
| push_pull | output | 1 | Output stage is in push-pull mode |
| card_state | output | 3 | Current state code |
| rca | output | 16 | Stored relative card address |
| ocr_valid | output | 1 | OCR response strobe |
| ocr_value | output | 32 | OCR response word |

## Verification
The bench builds the block with BUSY_CLKS set to 12, so both the busy answer and the ready answer to CMD1 fit within a few dozen clocks. It uses a 16-bit CID of 0xB4E1 instead of the 128-bit default, so every bit of a full arbitration round can be checked one by one. That pattern has both a 1 and a 0 among its leading bits. A competing card can therefore be modelled as losing on a 0 bit, which leaves the round intact, and as winning on a 1 bit, which makes the card drop out. A command injected in the middle of the round shows that the transmit state ignores it.

// File: rtl/mmc_ident_pkg.sv
package mmc_ident_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READY  = 3'd1,
        ST_IDENT  = 3'd2,
        ST_STBY   = 3'd3,
        ST_INACT  = 3'd4,
        ST_CIDTX  = 3'd5
    } card_state_e;

    localparam logic [5:0] CMD_OP_COND  = 6'd1;
    localparam logic [5:0] CMD_ALL_CID  = 6'd2;
    localparam logic [5:0] CMD_SET_ADDR = 6'd3;
    localparam logic [5:0] CMD_GO_INACT = 6'd15;

    localparam int ADDR_W = 16;

endpackage

// File: rtl/mmc_busy_timer.sv
module mmc_busy_timer #(
    parameter int BUSY_CLKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CLKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BUSY_CLKS);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign busy = (cnt != LIMIT);

    // Once the busy period has ended, the flag must stay clear until the next reset.
    AST_BUSY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy); // R2

endmodule

// File: rtl/mmc_volt_window.sv
module mmc_volt_window #(
    parameter logic [31:0] CARD_VDD = 32'h00FF_8000
) (
    input  logic [23:0] win_req,
    input  logic        busy,
    output logic        is_query,
    output logic        is_reject,
    output logic [31:0] ocr_word
);
    logic [23:0] overlap;

    always_comb begin
        overlap   = win_req & CARD_VDD[23:0];
        is_query  = (win_req == 24'd0);
        is_reject = !is_query && (overlap == 24'd0);
        ocr_word  = {!busy, CARD_VDD[30:0]};
    end

endmodule

// File: rtl/mmc_cid_arbiter.sv
module mmc_cid_arbiter #(
    parameter int CID_W = 128,
    parameter logic [CID_W-1:0] CID_VALUE = {(CID_W/16){16'hC39A}}
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic line_in,
    output logic drive_low,
    output logic won,
    output logic lost
);
    localparam int IDX_W = $clog2(CID_W);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(CID_W - 1);

    logic             active;
    logic [IDX_W-1:0] pos;
    logic             cur_bit;
    logic             mismatch;

    always_comb begin
        cur_bit   = CID_VALUE[pos];
        mismatch  = active && (line_in != cur_bit);
        lost      = mismatch;
        won       = active && !mismatch && (pos == '0);
        drive_low = active && !cur_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            pos    <= '0;
        end else if (start) begin
            active <= 1'b1;
            pos    <= TOP;
        end else if (active) begin
            if (mismatch || pos == '0) begin
                active <= 1'b0;
            end else begin
                pos <= pos - 1'b1;
            end
        end
    end

    // A lost bit must release the line in the next cycle.
    AST_RELEASE_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && !start) |=> !drive_low); // R8

endmodule

// File: rtl/mmc_ident_ctrl.sv
module mmc_ident_ctrl
    import mmc_ident_pkg::*;
#(
    parameter int BUSY_CLKS = 1000,
    parameter logic [31:0] CARD_VDD = 32'h00FF_8000,
    parameter int CID_W = 128,
    parameter logic [CID_W-1:0] CID_VALUE = {(CID_W/16){16'hC39A}}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [5:0]  cmd_index,
    input  logic [31:0] cmd_arg,
    input  logic        line_in,
    output logic        od_drive_low,
    output logic        push_pull,
    output logic [2:0]  card_state,
    output logic [15:0] rca,
    output logic        ocr_valid,
    output logic [31:0] ocr_value
);
    card_state_e state, nxt;

    logic busy, is_query, is_reject, cid_won, cid_lost, cid_start;
    logic [31:0] ocr_word;
    logic hit_op, hit_cid, hit_addr, hit_inact;

    assign hit_op    = cmd_valid && (cmd_index == CMD_OP_COND);
    assign hit_cid   = cmd_valid && (cmd_index == CMD_ALL_CID);
    assign hit_addr  = cmd_valid && (cmd_index == CMD_SET_ADDR);
    assign hit_inact = cmd_valid && (cmd_index == CMD_GO_INACT);
    assign cid_start = (state == ST_READY) && hit_cid;

    mmc_busy_timer #(.BUSY_CLKS(BUSY_CLKS)) u_busy (
        .clk  (clk),
        .rst_n(rst_n),
        .busy (busy)
    );

    mmc_volt_window #(.CARD_VDD(CARD_VDD)) u_volt (
        .win_req  (cmd_arg[23:0]),
        .busy     (busy),
        .is_query (is_query),
        .is_reject(is_reject),
        .ocr_word (ocr_word)
    );

    mmc_cid_arbiter #(.CID_W(CID_W), .CID_VALUE(CID_VALUE)) u_cid (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cid_start),
        .line_in  (line_in),
        .drive_low(od_drive_low),
        .won      (cid_won),
        .lost     (cid_lost)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (hit_inact)                               nxt = ST_INACT;
                else if (hit_op && is_reject)                nxt = ST_INACT;
                else if (hit_op && !is_query && !busy)       nxt = ST_READY;
            end
            ST_READY: begin
                if (hit_inact)      nxt = ST_INACT;
                else if (hit_cid)   nxt = ST_CIDTX;
            end
            ST_CIDTX: begin
                if (cid_won)        nxt = ST_IDENT;
                else if (cid_lost)  nxt = ST_READY;
            end
            ST_IDENT: begin
                if (hit_inact)      nxt = ST_INACT;
                else if (hit_addr)  nxt = ST_STBY;
            end
            ST_STBY: begin
                if (hit_inact)      nxt = ST_INACT;
            end
            ST_INACT: nxt = ST_INACT;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rca       <= '0;
            ocr_valid <= 1'b0;
            ocr_value <= '0;
        end else begin
            ocr_valid <= (state == ST_IDLE) && hit_op && !is_reject;
            if ((state == ST_IDLE) && hit_op && !is_reject) begin
                ocr_value <= ocr_word;
            end
            if ((state == ST_IDENT) && hit_addr) begin
                rca <= cmd_arg[31:16];
            end
        end
    end

    // Combinational outputs
    always_comb begin
        card_state = state;
        push_pull  = (state == ST_STBY);
    end

    AST_INACT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INACT) |=> (state == ST_INACT)); // R5

    AST_DRIVE_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
        od_drive_low |-> (state == ST_CIDTX)); // R7

    AST_IDENT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDENT && $past(state) != ST_IDENT) |-> ($past(state) == ST_CIDTX)); // R9

    AST_STBY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STBY && $past(state) != ST_STBY) |-> ($past(state) == ST_IDENT)); // R10

    AST_RCA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STBY && $past(state) == ST_STBY) |-> $stable(rca)); // R11

    AST_OCR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ocr_valid |-> ($past(cmd_valid) && $past(cmd_index) == CMD_OP_COND)); // R3

endmodule

// File: tb/sim_mmc_ident_ctrl.sv
module sim_mmc_ident_ctrl;
    localparam int BUSY = 12;
    localparam int CW = 16;
    localparam logic [CW-1:0] CID = 16'hB4E1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [5:0] cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic force_low = 1'b0;
    logic line_in;
    logic od_drive_low, push_pull, ocr_valid;
    logic [2:0] card_state;
    logic [15:0] rca;
    logic [31:0] ocr_value;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    // Wired-AND line: either the card or a competing card may pull it low.
    assign line_in = !od_drive_low && !force_low;

    mmc_ident_ctrl #(.BUSY_CLKS(BUSY), .CID_W(CW), .CID_VALUE(CID)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .line_in(line_in), .od_drive_low(od_drive_low),
        .push_pull(push_pull), .card_state(card_state), .rca(rca),
        .ocr_valid(ocr_valid), .ocr_value(ocr_value)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; force_low = 1'b0; cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cmd(input logic [5:0] idx, input logic [31:0] arg);
        cmd_valid = 1'b1; cmd_index = idx; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_index = '0; cmd_arg = '0;
    endtask

    task automatic to_ready();
        do_reset();
        repeat (BUSY + 2) @(negedge clk);
        cmd(6'd1, 32'h0030_0000);
    endtask

    // Runs one CID round; the competing card pulls low at fail_at and at zero_at.
    task automatic cid_round(input int fail_at, input int zero_at, input bit inject);
        cmd(6'd2, 32'h0);
        chk("R7 state CID-transmit", card_state, 3'd5);
        for (int i = 0; i < CW; i++) begin
            chk("R7 line drive per bit", od_drive_low, !CID[CW-1-i]);
            force_low = (i == fail_at) || (i == zero_at);
            if (inject && i == 3) begin
                cmd_valid = 1'b1; cmd_index = 6'd15;
            end
            @(negedge clk);
            cmd_valid = 1'b0; cmd_index = '0;
            force_low = 1'b0;
            if (i == fail_at) break;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 state", card_state, 3'd0);
        chk("R1 drive", od_drive_low, 1'b0);
        chk("R1 push_pull", push_pull, 1'b0);
        chk("R1 ocr_valid", ocr_valid, 1'b0);
        chk("R1 rca", rca, 16'h0);
    endtask

    task automatic t_busy();
        do_reset();
        cmd(6'd1, 32'h0030_0000);
        chk("R2 ocr_valid", ocr_valid, 1'b1);
        chk("R2 busy ocr", ocr_value, 32'h00FF_8000);
        chk("R2 stays idle", card_state, 3'd0);
        cmd(6'd2, 32'h0);
        chk("R12 CMD2 in idle", card_state, 3'd0);
        chk("R12 no drive in idle", od_drive_low, 1'b0);
    endtask

    task automatic t_ready();
        to_ready();
        chk("R3 ocr_valid", ocr_valid, 1'b1);
        chk("R3 ready ocr", ocr_value, 32'h80FF_8000);
        chk("R3 state ready", card_state, 3'd1);
        @(negedge clk);
        chk("R3 one-cycle strobe", ocr_valid, 1'b0);
        cmd(6'd3, 32'h1234_0000);
        chk("R12 CMD3 in ready state", card_state, 3'd1);
        chk("R12 CMD3 in ready rca", rca, 16'h0);
    endtask

    task automatic t_query();
        do_reset();
        repeat (BUSY + 2) @(negedge clk);
        cmd(6'd1, 32'h0);
        chk("R4 query ocr_valid", ocr_valid, 1'b1);
        chk("R4 query ocr", ocr_value, 32'h80FF_8000);
        chk("R4 stays idle", card_state, 3'd0);
    endtask

    task automatic t_arbitrate();
        to_ready();
        cid_round(2, -1, 1'b0);
        chk("R8 back to ready", card_state, 3'd1);
        chk("R8 line released", od_drive_low, 1'b0);
        cid_round(-1, 1, 1'b1);
        chk("R9 identified", card_state, 3'd2);
        chk("R12 CMD15 during transmit ignored", card_state, 3'd2);
        chk("R9 line released", od_drive_low, 1'b0);
    endtask

    task automatic t_standby();
        cmd(6'd3, 32'h5A3C_0000);
        chk("R10 state standby", card_state, 3'd3);
        chk("R10 rca", rca, 16'h5A3C);
        chk("R10 push_pull", push_pull, 1'b1);
        cmd(6'd1, 32'h0030_0000);
        chk("R11 no ocr", ocr_valid, 1'b0);
        cmd(6'd2, 32'h0);
        chk("R11 no drive", od_drive_low, 1'b0);
        cmd(6'd3, 32'h7777_0000);
        chk("R11 state", card_state, 3'd3);
        chk("R11 rca kept", rca, 16'h5A3C);
        chk("R11 push_pull kept", push_pull, 1'b1);
        cmd(6'd15, 32'h0);
        chk("R6 standby to inactive", card_state, 3'd4);
        chk("R6 push_pull off", push_pull, 1'b0);
        cmd(6'd1, 32'h0030_0000);
        chk("R5 inactive ignores CMD1", card_state, 3'd4);
        chk("R5 inactive no ocr", ocr_valid, 1'b0);
        do_reset();
        chk("R5 reset leaves inactive", card_state, 3'd0);
    endtask

    task automatic t_incompat();
        do_reset();
        repeat (BUSY + 2) @(negedge clk);
        cmd(6'd1, 32'h0000_0100);
        chk("R5 reject to inactive", card_state, 3'd4);
        chk("R5 reject no ocr", ocr_valid, 1'b0);
        cmd(6'd1, 32'h0030_0000);
        chk("R5 still inactive", card_state, 3'd4);
        do_reset();
        cmd(6'd15, 32'h0);
        chk("R6 idle to inactive", card_state, 3'd4);
        to_ready();
        cmd(6'd15, 32'h0);
        chk("R6 ready to inactive", card_state, 3'd4);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog all R actual=hung expected=finished");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_busy();
        t_ready();
        t_query();
        t_arbitrate();
        t_standby();
        t_incompat();
        finish_run();
    end

endmodule